// File: doc/BRIEF.md
# Bit-Test-Under-Mask Execution Unit

This unit carries out the test-under-mask instruction group of an 8-bit processor whose operands live in a 256-byte register file. It is handed an instruction that has already been fetched: an opcode plus one or two operand bytes. It works out where the mask and the tested value come from, reads them one at a time through a synchronous register-file read port, and ANDs the tested value with the mask. From that result it produces new zero, sign and overflow flags. Nothing is ever written back to the register file.

Five opcodes are accepted. Each one pairs a different source form (working register, plain register, register-indirect or immediate) with a different destination form (working register, plain register or register-indirect). Working registers sit in a 16-byte bank whose upper address nibble is supplied on `wr_bank`. The unit raises `done` for a single cycle when `flags_out` has been updated. Any other opcode is reported on `illegal`, and the flags stay as they were.

Top module: `tm_exec_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `busy` and `rf_re` are 0 and `flags_out` is 00h.
- R2: For a legal opcode, flag bit 6 (zero) is 1 when the AND of mask and tested value is 00h, and 0 otherwise.
- R3: For a legal opcode, flag bit 5 (sign) equals bit 7 of the AND of mask and tested value. A tested bit 7 that is not selected by the mask leaves it 0.
- R4: For a legal opcode, flag bit 4 (overflow) is cleared. Bit 7 (carry) and bits 3:0 keep the values `flags_in` had when `start` was accepted.
- R5: A working-register reference (a nibble of opcode 73h, or an operand byte whose upper nibble is Eh) with index x addresses `{wr_bank, x}`. Any other operand byte is used directly as an address.
- R6: Opcode 74h: `op_b1` addresses the mask and `op_b2` addresses the tested value.
- R7: Opcode 75h: the register addressed by `op_b1` holds the address of the mask, and `op_b2` addresses the tested value.
- R8: Opcode 76h: `op_b1` addresses the tested value and `op_b2` is the immediate mask.
- R9: Opcode 77h: the register addressed by `op_b1` holds the address of the tested value, and `op_b2` is the immediate mask.
- R10: Opcode 73h: `op_b1[3:0]` names a working register whose contents give the address of the mask, and `op_b1[7:4]` names the working register holding the tested value.
- R11: Any opcode other than 73h to 77h raises `illegal` together with `done`, leaves `flags_out` equal to the captured `flags_in`, and performs no register-file read.
- R12: `done` is a one-cycle pulse. It arrives N+1 clock edges after the edge that accepts `start`, where N is the number of reads: 3 for 73h and 75h, 2 for 74h and 77h, 1 for 76h, 0 for an illegal opcode. `busy` is high from acceptance until `done`, and a `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept the instruction on the opcode/operand inputs when idle |
| opcode | input | 8 | Instruction opcode |
| op_b1 | input | 8 | First operand byte |
| op_b2 | input | 8 | Second operand byte (unused by 73h) |
| wr_bank | input | 4 | Upper address nibble of the working-register bank |
| flags_in | input | 8 | Current flag byte: bit 7 carry, 6 zero, 5 sign, 4 overflow |
| rf_re | output | 1 | Register-file read enable |
| rf_addr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Read data, valid the cycle after `rf_re` |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse: `flags_out` updated |
| illegal | output | 1 | With `done`: the opcode was not in the test-under-mask group |
| flags_out | output | 8 | Resulting flag byte |

## Verification
The assertions assume a register file that returns the addressed byte exactly one cycle after each read enable and holds `rf_rdata` between reads. The bench's behavioural memory model does this. They also assume that `flags_in` and the operand inputs only matter at the accepting edge. The stimulus therefore changes them freely while the unit is busy, including one extra `start` pulse carrying an illegal opcode, which must leave the running instruction unaffected. Register contents are set up before each instruction and held constant while it executes, so the reference model's reads match the unit's.

// File: rtl/tm_pkg.sv
// Package: shared constants and types for the test-under-mask unit.
// Assumes an 8-bit datapath and a 256-byte register file.
package tm_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int BANK_W    = AW - 4;
    localparam int FLG_C     = 7;
    localparam int FLG_Z     = 6;
    localparam int FLG_S     = 5;
    localparam int FLG_V     = 4;
    localparam logic [3:0] WR_TAG = 4'hE;

    localparam logic [7:0] OP_WW_IND = 8'h73;
    localparam logic [7:0] OP_RR     = 8'h74;
    localparam logic [7:0] OP_RR_IND = 8'h75;
    localparam logic [7:0] OP_R_IMM  = 8'h76;
    localparam logic [7:0] OP_IR_IMM = 8'h77;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SRC_A = 3'd1,
        ST_SRC_I = 3'd2,
        ST_DST_A = 3'd3,
        ST_DST_I = 3'd4,
        ST_EVAL  = 3'd5
    } tm_state_e;

    typedef struct packed {
        logic          legal;
        logic          src_imm;
        logic          src_ind;
        logic          dst_ind;
        logic [AW-1:0] src_ref;
        logic [AW-1:0] dst_ref;
        logic [DW-1:0] imm;
    } tm_dec_t;
endpackage

// File: rtl/tm_decode.sv
// Module: opcode decoder. Turns an opcode and its operand bytes into
// operand references. A working-register nibble is re-expressed as an
// Ex byte, so one resolver handles both encodings.
// Assumes: purely combinational; validity is judged by the caller.
module tm_decode
    import tm_pkg::*;
(
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] op_b1,
    input  logic [DW-1:0] op_b2,
    output tm_dec_t       dec
);
    // Purpose: map each opcode to its source and destination forms.
    always_comb begin
        dec     = '0;
        dec.imm = op_b2;
        case (opcode)
            OP_WW_IND: begin
                dec.legal   = 1'b1;
                dec.src_ind = 1'b1;
                dec.src_ref = {WR_TAG, op_b1[3:0]};
                dec.dst_ref = {WR_TAG, op_b1[7:4]};
            end
            OP_RR: begin
                dec.legal   = 1'b1;
                dec.src_ref = op_b1;
                dec.dst_ref = op_b2;
            end
            OP_RR_IND: begin
                dec.legal   = 1'b1;
                dec.src_ind = 1'b1;
                dec.src_ref = op_b1;
                dec.dst_ref = op_b2;
            end
            OP_R_IMM: begin
                dec.legal   = 1'b1;
                dec.src_imm = 1'b1;
                dec.dst_ref = op_b1;
            end
            OP_IR_IMM: begin
                dec.legal   = 1'b1;
                dec.src_imm = 1'b1;
                dec.dst_ind = 1'b1;
                dec.dst_ref = op_b1;
            end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/tm_operand_addr.sv
// Module: operand address resolver. A reference byte whose upper nibble
// is the working-register tag selects a register in the current bank;
// any other byte is a direct register-file address.
// Assumes: bank is stable while the address is in use.
module tm_operand_addr
    import tm_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [AW-1:0]     ref_byte,
    output logic [AW-1:0]     addr
);
    // Purpose: substitute the bank nibble for working-register references.
    always_comb begin
        if (ref_byte[AW-1:AW-4] == WR_TAG) addr = {bank, ref_byte[3:0]};
        else                               addr = ref_byte;
    end
endmodule

// File: rtl/tm_flag_eval.sv
// Module: flag evaluator. ANDs the tested value with the mask and forms
// the new flag byte; an illegal instruction passes the flags through.
// Assumes: inputs are valid in the evaluation cycle only.
module tm_flag_eval
    import tm_pkg::*;
(
    input  logic [DW-1:0] flags_prev,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] value,
    input  logic          legal,
    output logic [DW-1:0] flags_next
);
    logic [DW-1:0] masked;

    // Purpose: compute zero/sign from the masked value and clear overflow.
    always_comb begin
        masked     = mask & value;
        flags_next = flags_prev;
        if (legal) begin
            flags_next[FLG_Z] = (masked == '0);
            flags_next[FLG_S] = masked[DW-1];
            flags_next[FLG_V] = 1'b0;
        end
    end
endmodule

// File: rtl/tm_exec_unit.sv
// Module: test-under-mask execution unit (top). Captures an instruction
// on start, sequences up to three register-file reads (source pointer,
// source, destination pointer/value), then updates the flags and pulses
// done. Never writes the register file.
// Assumes: rf_rdata holds the addressed byte one cycle after rf_re and
// keeps it until the next read.
module tm_exec_unit
    import tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DW-1:0]     op_b1,
    input  logic [DW-1:0]     op_b2,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [DW-1:0]     flags_in,
    output logic              rf_re,
    output logic [AW-1:0]     rf_addr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DW-1:0]     flags_out
);
    localparam int N_REF = 2;

    tm_state_e         st_q, st_d;
    tm_dec_t           dec_in, dec_q;
    logic [BANK_W-1:0] bank_q;
    logic [DW-1:0]     flg_q;
    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     flags_q;
    logic [DW-1:0]     flags_nx;
    logic              done_q;
    logic              ill_q;
    logic [N_REF-1:0][AW-1:0] ref_bytes;
    logic [N_REF-1:0][AW-1:0] ref_addrs;

    tm_decode u_decode (
        .opcode (opcode),
        .op_b1  (op_b1),
        .op_b2  (op_b2),
        .dec    (dec_in)
    );

    assign ref_bytes[0] = dec_q.src_ref;
    assign ref_bytes[1] = dec_q.dst_ref;

    for (genvar g = 0; g < N_REF; g++) begin : g_resolve
        tm_operand_addr u_addr (
            .bank     (bank_q),
            .ref_byte (ref_bytes[g]),
            .addr     (ref_addrs[g])
        );
    end

    tm_flag_eval u_flags (
        .flags_prev (flg_q),
        .mask       (mask_q),
        .value      (rf_rdata),
        .legal      (dec_q.legal),
        .flags_next (flags_nx)
    );

    // Purpose: next-state and read-port control of the read sequence.
    always_comb begin
        st_d    = st_q;
        rf_re   = 1'b0;
        rf_addr = ref_addrs[0];
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (!dec_in.legal)      st_d = ST_EVAL;
                    else if (dec_in.src_imm) st_d = ST_DST_A;
                    else                     st_d = ST_SRC_A;
                end
            end
            ST_SRC_A: begin
                rf_re   = 1'b1;
                rf_addr = ref_addrs[0];
                st_d    = dec_q.src_ind ? ST_SRC_I : ST_DST_A;
            end
            ST_SRC_I: begin
                rf_re   = 1'b1;
                rf_addr = rf_rdata;
                st_d    = ST_DST_A;
            end
            ST_DST_A: begin
                rf_re   = 1'b1;
                rf_addr = ref_addrs[1];
                st_d    = dec_q.dst_ind ? ST_DST_I : ST_EVAL;
            end
            ST_DST_I: begin
                rf_re   = 1'b1;
                rf_addr = rf_rdata;
                st_d    = ST_EVAL;
            end
            ST_EVAL:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: capture the instruction, latch the mask, publish flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q   <= '0;
            bank_q  <= '0;
            flg_q   <= '0;
            mask_q  <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (st_q == ST_IDLE && start) begin
                dec_q  <= dec_in;
                bank_q <= wr_bank;
                flg_q  <= flags_in;
                mask_q <= dec_in.imm;
            end
            if (st_q == ST_DST_A && !dec_q.src_imm) mask_q <= rf_rdata;
            if (st_q == ST_EVAL) begin
                done_q  <= 1'b1;
                ill_q   <= !dec_q.legal;
                flags_q <= flags_nx;
            end
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign illegal   = ill_q;
    assign flags_out = flags_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R12
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dec_q));                               // R12
    AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> !flags_out[FLG_V]);                         // R4
    AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLG_C] == flg_q[FLG_C] && flags_out[3:0] == flg_q[3:0])); // R4
    AST_SIGN_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && flags_out[FLG_S]) |-> !flags_out[FLG_Z]);     // R3
    AST_ILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (flags_out == flg_q));                       // R11
    AST_ILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dec_q.legal) |-> !rf_re);                                // R11
endmodule

// File: tb/tm_exec_unit_tb.sv
module tm_exec_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = 8'h00, op_b1 = 8'h00, op_b2 = 8'h00;
    logic [3:0] wr_bank = 4'h0;
    logic [7:0] flags_in = 8'h00;
    logic       rf_re;
    logic [7:0] rf_addr;
    logic [7:0] rf_rdata = 8'h00;
    logic       busy, done, illegal;
    logic [7:0] flags_out;

    logic [7:0] mem [256];
    int checks = 0, failures = 0, rd_cnt = 0, cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    tm_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_b1(op_b1), .op_b2(op_b2), .wr_bank(wr_bank), .flags_in(flags_in),
        .rf_re(rf_re), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .busy(busy), .done(done), .illegal(illegal), .flags_out(flags_out)
    );

    // Behavioural register file: one-cycle synchronous read, holds data.
    always @(posedge clk) begin
        if (rf_re) begin
            rf_rdata <= mem[rf_addr];
            rd_cnt   <= rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] res(input logic [7:0] b, input logic [3:0] bank);
        return (b[7:4] == 4'hE) ? {bank, b[3:0]} : b;   // R5
    endfunction

    // Run one instruction against the reference model, comparing every clock.
    task automatic exec(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [3:0] bank, input logic [7:0] fin,
                        input bit glitch, input string req);
        logic [7:0] m, v, ef;
        int nrd, lat, bad;
        bit legal;
        legal = 1'b1; m = 8'h00; v = 8'h00; nrd = 0;
        case (op)
            8'h73: begin m = mem[mem[{bank, b1[3:0]}]]; v = mem[{bank, b1[7:4]}]; nrd = 3; end
            8'h74: begin m = mem[res(b1, bank)]; v = mem[res(b2, bank)]; nrd = 2; end
            8'h75: begin m = mem[mem[res(b1, bank)]]; v = mem[res(b2, bank)]; nrd = 3; end
            8'h76: begin m = b2; v = mem[res(b1, bank)]; nrd = 1; end
            8'h77: begin m = b2; v = mem[mem[res(b1, bank)]]; nrd = 2; end
            default: legal = 1'b0;
        endcase
        ef = fin;
        if (legal) begin
            ef[6] = ((m & v) == 8'h00);
            ef[5] = (m[7] & v[7]);
            ef[4] = 1'b0;
        end
        lat = nrd + 1;
        bad = 0;
        @(negedge clk);
        rd_cnt = 0;
        start = 1'b1; opcode = op; op_b1 = b1; op_b2 = b2; wr_bank = bank; flags_in = fin;
        for (int c = 0; c <= lat; c++) begin
            @(negedge clk);
            if (c == 0 && glitch) begin
                start = 1'b1; opcode = 8'h72; op_b1 = 8'h00; op_b2 = 8'h00;
                wr_bank = ~bank; flags_in = ~fin;
            end else begin
                start = 1'b0; flags_in = 8'h5A;
            end
            if (done !== (c == lat)) bad++;
            if (busy !== (c < lat)) bad++;
            if (c == lat && illegal !== !legal) bad++;
        end
        check({req, " R12 timing"}, bad, 0);
        check({req, " flags"}, flags_out, ef);
        check({req, " read count"}, rd_cnt, nrd);
        @(negedge clk);
        check({req, " R12 pulse end"}, {done, busy}, 2'b00);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        check("R1 reset", {done, illegal, busy, rf_re, flags_out}, 12'h000);
        rst_n = 1'b1;
        // R10 opcode 73h: ptr at R5, mask via ptr, value in R14
        mem[8'h15] = 8'h40; mem[8'h40] = 8'h80; mem[8'h1E] = 8'hFF;
        exec(8'h73, 8'hE5, 8'h00, 4'h1, 8'h00, 1'b0, "R10 R3 ind");
        // R6 opcode 74h with working-register source (R5 mapping)
        mem[8'h10] = 8'h04; mem[8'hD4] = 8'h08;
        exec(8'h74, 8'hE0, 8'hD4, 4'h1, 8'h00, 1'b0, "R6 R5 R2 wr");
        // R6 plain registers, selected bit set
        mem[8'h33] = 8'hC3; mem[8'h34] = 8'h41;
        exec(8'h74, 8'h33, 8'h34, 4'h1, 8'hF0, 1'b0, "R6 R2 plain");
        // R7 opcode 75h
        mem[8'hDF] = 8'h00; mem[8'h07] = 8'h1F; mem[8'h1F] = 8'hBD;
        exec(8'h75, 8'h07, 8'hDF, 4'h1, 8'h00, 1'b0, "R7 ind src");
        // R8 opcode 76h with bank 2
        mem[8'h2D] = 8'hF1;
        exec(8'h76, 8'hED, 8'h02, 4'h2, 8'h00, 1'b0, "R8 R5 imm");
        // R9 opcode 77h
        mem[8'h5D] = 8'hA0; mem[8'hA0] = 8'h0F;
        exec(8'h77, 8'h5D, 8'h10, 4'h1, 8'h00, 1'b0, "R9 ind dst");
        // R9 indirect through a working register
        mem[8'h33] = 8'h90; mem[8'h90] = 8'h83;
        exec(8'h77, 8'hE3, 8'h81, 4'h3, 8'h00, 1'b0, "R9 R5 R3 wr ind");
        // R3 bit 7 set but not selected
        mem[8'h60] = 8'h80;
        exec(8'h76, 8'h60, 8'h7F, 4'h1, 8'h20, 1'b0, "R3 unselected");
        // R2 empty mask
        mem[8'h61] = 8'hFF;
        exec(8'h76, 8'h61, 8'h00, 4'h1, 8'h00, 1'b0, "R2 zero mask");
        // R4 carry and low bits preserved, overflow cleared
        exec(8'h76, 8'h61, 8'h01, 4'h1, 8'h9F, 1'b0, "R4 keep");
        exec(8'h76, 8'h61, 8'h80, 4'h1, 8'h7A, 1'b0, "R4 keep2");
        // R11 illegal opcodes either side of the group
        exec(8'h72, 8'hE5, 8'h00, 4'h1, 8'hFF, 1'b0, "R11 low");
        exec(8'h78, 8'h33, 8'h34, 4'h1, 8'h3C, 1'b0, "R11 high");
        // R12 start while busy ignored
        exec(8'h75, 8'h07, 8'hDF, 4'h1, 8'h81, 1'b1, "R12 busy start");
        exec(8'h73, 8'hE5, 8'h00, 4'h1, 8'h10, 1'b1, "R12 busy start2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule